// File: doc/BRIEF.md
# Received Test Pattern Checker

This block sits in the receive path after deserialization. It checks each incoming sample word against a pattern that it generates locally. The pattern is either a 23-bit pseudo-random sequence or a 16-bit ramp. The link may run with 16-bit or 14-bit words. In 14-bit mode the local 16-bit expected word goes through the same narrowing as the transmitter. That narrowing drops the two low bits, adds back bit 1 as a rounding increment, and holds the positive full-scale code so that it does not wrap to negative. If the checker did not copy this, a healthy link would show repeatable false errors wherever bit 15 of the pattern changes.

A resync pulse restarts the local generator from its seed. The generator moves forward only on valid samples, so gaps in the stream do not break alignment. The outputs are a one-cycle mismatch flag per sample, a saturating error count that software can clear, and a lock indication that rises after a run of matching samples. A multi-channel receiver uses one instance per channel.

Top module: `rx_pattern_checker`

## Requirements
- R1: In PRBS mode (`pat_prbs`=1) the 16-bit expected word is bits [15:0] of a 23-bit shift register. On each step the register shifts up by one, and the XOR of bits 22 and 17 enters bit 0, which gives the polynomial x^23 + x^18 + 1. The register is all ones after a resync, so the first word is 0xFFFF and the second is 0xFFFE.
- R2: In ramp mode (`pat_prbs`=0) the expected 16-bit word is 0 after a resync. It rises by one per valid sample and wraps from 0xFFFF to 0.
- R3: In 16-bit mode (`narrow`=0) all 16 bits of `smp_data` are compared. A difference in any single bit, including bit 15 and bit 0, is a mismatch.
- R4: In 14-bit mode (`narrow`=1) the received word is `smp_data[13:0]`, and `smp_data[15:14]` has no effect. The expected value is w[15:2] + w[1] modulo 2^14, where w is the 16-bit expected word. The one exception is w[15:2] = 0x1FFF with w[1] = 1: the result is then held at 0x1FFF. For the ramp this gives 0x1FFF for six samples, then 0x2000 for two.
- R5: Both local generators advance only on samples with `smp_valid`=1. Cycles without a valid sample leave the expected sequence unchanged.
- R6: `mismatch` is 1 in the cycle after a valid sample that differs from the expected value. In every other cycle it is 0.
- R7: `err_count` rises by one with each mismatch and saturates at 2^CNT_W-1 without wrapping.
- R8: `cnt_clr` sets `err_count` to 0 at the next edge. The clear takes priority over an increment in the same cycle.
- R9: `locked` rises at the edge that registers the LOCK_LEN-th consecutive matching valid sample. It falls at the edge that registers any mismatch.
- R10: `resync` reseeds both generators and clears `locked` and the match run. A valid sample in the same cycle is compared with the seed word and counts as the first sample of the new run.
- R11: After reset, `mismatch`, `err_count` and `locked` are 0, and the generators hold their seed values as if a resync had just occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Marks a received sample on `smp_data` |
| smp_data | input | 16 | Received word; in 14-bit mode only [13:0] is used |
| resync | input | 1 | Reseeds the generators and clears lock |
| pat_prbs | input | 1 | 1 selects the PRBS pattern, 0 selects the ramp |
| narrow | input | 1 | 1 selects 14-bit rounded comparison, 0 selects 16-bit |
| cnt_clr | input | 1 | Clears the error counter |
| mismatch | output | 1 | Registered per-sample mismatch flag |
| err_count | output | CNT_W | Saturating mismatch count |
| locked | output | 1 | High after LOCK_LEN consecutive matches |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a resync and a valid sample: the sample must be judged against the seed word, not the old sequence. The bench provokes this while the checker is locked, once with the correct seed word and once with a corrupted word, and expects the lock to drop in both cases and a mismatch only in the second. The second pair is a counter clear and a bad sample. The bench presents them together and expects a zero count next to a raised mismatch flag.

// File: rtl/rxpc_pkg.sv
package rxpc_pkg;
  localparam int FULL_W   = 16;
  localparam int NARROW_W = 14;
  localparam int DROP_W   = FULL_W - NARROW_W;
  localparam int PRBS_W   = 23;
  localparam int PRBS_TAP = 18;

  // One step of the x^23 + x^18 + 1 shift register.
  function automatic logic [PRBS_W-1:0] prbs_next(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_TAP-1]};
  endfunction

  // Narrow a two's-complement word: round half up, hold positive full scale.
  function automatic logic [NARROW_W-1:0] round_narrow(input logic [FULL_W-1:0] w);
    logic [NARROW_W-1:0] upper;
    logic                at_pos_max;
    upper      = w[FULL_W-1:DROP_W];
    at_pos_max = (upper == {1'b0, {(NARROW_W-1){1'b1}}});
    if (at_pos_max || !w[DROP_W-1]) return upper;
    return upper + 1'b1;
  endfunction
endpackage

// File: rtl/rxpc_gen.sv
module rxpc_gen
  import rxpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              resync,
  output logic [FULL_W-1:0] prbs_word,
  output logic [FULL_W-1:0] ramp_word
);
  localparam logic [PRBS_W-1:0] SEED = '1;

  logic [PRBS_W-1:0] lfsr_q, lfsr_cur;
  logic [FULL_W-1:0] ramp_q, ramp_cur;

  always_comb begin
    lfsr_cur = resync ? SEED : lfsr_q;
    ramp_cur = resync ? '0   : ramp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      ramp_q <= '0;
    end else if (valid) begin
      lfsr_q <= prbs_next(lfsr_cur);
      ramp_q <= ramp_cur + 1'b1;
    end else begin
      lfsr_q <= lfsr_cur;
      ramp_q <= ramp_cur;
    end
  end

  assign prbs_word = lfsr_cur[FULL_W-1:0];
  assign ramp_word = ramp_cur;

  a_r10_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && !valid) |=> (lfsr_q == SEED && ramp_q == '0));

  a_r5_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !resync) |=> ($stable(lfsr_q) && $stable(ramp_q)));

  a_r2_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !resync) |=> (ramp_q == $past(ramp_q) + 1'b1));
endmodule

// File: rtl/rxpc_cmp.sv
module rxpc_cmp
  import rxpc_pkg::*;
(
  input  logic [FULL_W-1:0] prbs_word,
  input  logic [FULL_W-1:0] ramp_word,
  input  logic              pat_prbs,
  input  logic              narrow,
  input  logic [FULL_W-1:0] rx_word,
  output logic              hit
);
  logic [FULL_W-1:0]   exp_full;
  logic [NARROW_W-1:0] exp_narrow;

  always_comb begin
    exp_full   = pat_prbs ? prbs_word : ramp_word;
    exp_narrow = round_narrow(exp_full);
    if (narrow) hit = (rx_word[NARROW_W-1:0] == exp_narrow);
    else        hit = (rx_word == exp_full);
  end
endmodule

// File: rtl/rxpc_track.sv
module rxpc_track #(
  parameter int CNT_W    = 16,
  parameter int LOCK_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             hit,
  input  logic             resync,
  input  logic             cnt_clr,
  output logic             mismatch,
  output logic [CNT_W-1:0] err_count,
  output logic             locked
);
  localparam int               RUN_W   = $clog2(LOCK_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_LEN - 1);

  logic [RUN_W-1:0] run_q, run_base;
  logic             lock_base;
  wire              miss_ev = valid && !hit;
  wire              hit_ev  = valid && hit;

  always_comb begin
    run_base  = resync ? '0   : run_q;
    lock_base = resync ? 1'b0 : locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mismatch  <= 1'b0;
      err_count <= '0;
      run_q     <= '0;
      locked    <= 1'b0;
    end else begin
      mismatch <= miss_ev;
      if (cnt_clr)                           err_count <= '0;
      else if (miss_ev && err_count != CNT_MAX) err_count <= err_count + 1'b1;
      if (miss_ev) begin
        run_q  <= '0;
        locked <= 1'b0;
      end else if (hit_ev && run_base >= RUN_TOP) begin
        run_q  <= run_base;
        locked <= 1'b1;
      end else if (hit_ev) begin
        run_q  <= run_base + 1'b1;
        locked <= lock_base;
      end else begin
        run_q  <= run_base;
        locked <= lock_base;
      end
    end
  end

  a_r6_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> $past(valid));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (err_count >= $past(err_count)));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !cnt_clr) |=> (err_count == CNT_MAX));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (err_count == '0));

  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> !locked);

  a_r9_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit_ev));

  a_r10_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && !valid) |=> !locked);
endmodule

// File: rtl/rx_pattern_checker.sv
module rx_pattern_checker
  import rxpc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOCK_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [FULL_W-1:0] smp_data,
  input  logic              resync,
  input  logic              pat_prbs,
  input  logic              narrow,
  input  logic              cnt_clr,
  output logic              mismatch,
  output logic [CNT_W-1:0]  err_count,
  output logic              locked
);
  logic [FULL_W-1:0] prbs_word, ramp_word;
  logic              hit;

  rxpc_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (smp_valid),
    .resync    (resync),
    .prbs_word (prbs_word),
    .ramp_word (ramp_word)
  );

  rxpc_cmp u_cmp (
    .prbs_word (prbs_word),
    .ramp_word (ramp_word),
    .pat_prbs  (pat_prbs),
    .narrow    (narrow),
    .rx_word   (smp_data),
    .hit       (hit)
  );

  rxpc_track #(.CNT_W(CNT_W), .LOCK_LEN(LOCK_LEN)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (smp_valid),
    .hit       (hit),
    .resync    (resync),
    .cnt_clr   (cnt_clr),
    .mismatch  (mismatch),
    .err_count (err_count),
    .locked    (locked)
  );
endmodule

// File: tb/rx_pattern_checker_tb.sv
module rx_pattern_checker_tb;
  localparam int CW   = 8;
  localparam int LOCK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, resync = 1'b0, pat_prbs = 1'b1, narrow = 1'b0, cnt_clr = 1'b0;
  logic [15:0] smp_data = '0;
  logic mismatch, locked;
  logic [CW-1:0] err_count;

  int n_vec = 0, n_bad = 0;
  int m_lfsr = 32'h7FFFFF, m_ramp = 0, m_cnt = 0, m_run = 0;
  bit m_lock = 0;

  always #5 clk = ~clk;

  rx_pattern_checker #(.CNT_W(CW), .LOCK_LEN(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .resync(resync), .pat_prbs(pat_prbs), .narrow(narrow), .cnt_clr(cnt_clr),
    .mismatch(mismatch), .err_count(err_count), .locked(locked));

  function automatic int lfsr_step(input int s);
    int fb = ((s >> 22) ^ (s >> 17)) & 1;
    return ((s << 1) | fb) & 32'h7FFFFF;
  endfunction

  // Arithmetic form of the narrowing: floor((v+2)/4), capped at +8191.
  function automatic int narrow_of(input int w);
    int v = (w >= 32768) ? w - 65536 : w;
    int r = (v + 2) >>> 2;
    if (r > 8191) r = 8191;
    return r & 16'h3FFF;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input bit v, input bit rs, input bit clr, input logic [15:0] flip,
                       input string tag);
    int cur_l = rs ? 32'h7FFFFF : m_lfsr;
    int cur_r = rs ? 0 : m_ramp;
    int w = pat_prbs ? (cur_l & 16'hFFFF) : cur_r;
    logic [15:0] d;
    bit hit, miss;
    if (narrow) begin
      d   = {n_vec[1:0], 14'(narrow_of(w))} ^ flip;
      hit = (flip[13:0] == 14'h0);
    end else begin
      d   = 16'(w) ^ flip;
      hit = (flip == 16'h0);
    end
    miss = v && !hit;
    smp_valid = v; resync = rs; cnt_clr = clr; smp_data = d;
    if (v) begin
      m_lfsr = lfsr_step(cur_l);
      m_ramp = (cur_r + 1) & 16'hFFFF;
    end else begin
      m_lfsr = cur_l;
      m_ramp = cur_r;
    end
    if (clr) m_cnt = 0;
    else if (miss && m_cnt < (1 << CW) - 1) m_cnt++;
    if (rs) begin m_run = 0; m_lock = 0; end
    if (miss) begin m_run = 0; m_lock = 0; end
    else if (v) begin
      if (m_run < LOCK) m_run++;
      if (m_run >= LOCK) m_lock = 1;
    end
    @(negedge clk);
    n_vec++;
    check(tag, "mismatch", int'(mismatch), int'(miss));
    check(tag, "err_count", int'(err_count), m_cnt);
    check(tag, "locked", int'(locked), int'(m_lock));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    check("R11", "mismatch", int'(mismatch), 0);
    check("R11", "err_count", int'(err_count), 0);
    check("R11", "locked", int'(locked), 0);
    rst_n = 1'b1;
    // R11: generator seeded out of reset, first word 0xFFFF
    apply(1, 0, 0, 16'h0, "R11");
    // R1: PRBS 16-bit, lock after 64 matches (R9), single error (R6)
    apply(0, 1, 0, 16'h0, "R10");
    for (int i = 0; i < 200; i++) apply(1, 0, 0, 16'h0, (i > 55 && i < 70) ? "R9" : "R1");
    apply(1, 0, 0, 16'h0001, "R6");
    for (int i = 0; i < 80; i++) apply(1, 0, 0, 16'h0, "R9");
    // R3: top and bottom bit flips in 16-bit mode
    apply(1, 0, 0, 16'h8000, "R3");
    apply(1, 0, 0, 16'h0001, "R3");
    // R5: gaps carrying junk data
    for (int i = 0; i < 300; i++) apply(i % 3 != 1, 0, 0, (i % 3 == 1) ? 16'hA5A5 : 16'h0, "R5");
    // R10: resync coinciding with a valid sample while locked
    apply(1, 1, 0, 16'h0, "R10");
    for (int i = 0; i < 70; i++) apply(1, 0, 0, 16'h0, "R10");
    apply(1, 1, 0, 16'h0010, "R10");
    // R4: PRBS in 14-bit mode with junk in bits 15:14
    narrow = 1'b1;
    apply(1, 1, 0, 16'h0, "R4");
    for (int i = 0; i < 2000; i++) apply(1, 0, 0, 16'h0, "R4");
    apply(1, 0, 0, 16'h2000, "R4");
    // R2/R4: full ramp sweep in 14-bit mode, incl. clamp region
    pat_prbs = 1'b0;
    for (int i = 0; i < 65540; i++) begin
      if (i == 32766) apply(1, 0, 0, 16'h3FFF, "R4");  // unclamped 0x2000 must miss
      else apply(1, i == 0, 0, 16'h0, "R2");
    end
    // R2: ramp in 16-bit mode
    narrow = 1'b0;
    for (int i = 0; i < 300; i++) apply(1, 0, 0, 16'h0, "R2");
    // R7: saturation of the 8-bit counter
    for (int i = 0; i < 300; i++) apply(1, 0, 0, 16'h0004, "R7");
    // R8: clear coinciding with a mismatch, then count restarts
    apply(1, 0, 1, 16'h0004, "R8");
    apply(0, 0, 0, 16'h0, "R8");
    apply(1, 0, 0, 16'h0004, "R8");
    apply(0, 0, 1, 16'h0, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule